// File: doc/BRIEF.md
# PAL Video Field Capture Sequencer

This block sits directly behind a digital video decoder that delivers interleaved 4:2:2 PAL samples on a 27 MHz pixel clock. It reads the decoder's odd/even field flag and its vertical and horizontal reference levels, and turns them into per-sample qualifiers for the frame buffer and the frame-compare logic downstream. A capture frame begins when the field flag rises, which is the start of an odd field. From that point the block counts lines, follows the chroma/luma alternation inside each horizontal-reference run, and marks the luminance samples on odd-numbered active lines as valid.

The full raster is 864 samples by 625 lines, blanking included. Odd-field active lines are 23 to 310 and even-field active lines are 336 to 623. The block does not hard-code these windows. It uses the vertical reference level as the active-line indication, and the line counter simply runs from one frame start to the next. Frames take turns as store frames and compare frames, so one frame buffer is enough: a frame is written, and the next one is read back and compared against it.

The block registers the sync signals and the sample bus once. It then registers every output, and a second register is applied to the sample data so that sample_out stays level with its qualifiers. An input sampled on one clock edge therefore shows up on the outputs after the following edge.

Top module: `pal_field_sequencer`

## Requirements
- R1: While reset is held low, every output is 0: sample_out, sample_valid, luma_phase, line_lsb, line_count, frame_start, store_field and compare_field.
- R2: A 0-to-1 transition of field_odd produces exactly one cycle of frame_start, two clock edges after the first high sample is presented. A 1-to-0 transition produces no pulse.
- R3: line_count reads 0 on the frame_start cycle. It increases by one for every 1-to-0 transition of href and wraps modulo 2^LINE_W. line_lsb always equals bit 0 of line_count. A count change caused by a falling href appears on the sample after that falling sample.
- R4: luma_phase is 0 whenever href is low. Within each run of href-high samples, the first sample is chroma (luma_phase 0), the second is luma (1), and the phase then alternates on every sample.
- R5: Once armed, sample_valid is 1 exactly when vref is high, luma_phase is 1 and line_lsb is 1, all for the same sample.
- R6: After reset, sample_valid stays 0 until the first frame_start. vref and href activity before that point has no effect on it.
- R7: store_field and compare_field are both 0 before the first frame_start. The first frame after reset is a store frame (store_field 1). The role then toggles at every frame_start, and the two outputs are never 1 together.
- R8: sample_out equals sample_in delayed by two clock edges. It lines up with all qualifier outputs derived from that same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_odd | input | 1 | Field flag; high while the odd field is output |
| vref | input | 1 | Vertical reference; high during active lines |
| href | input | 1 | Horizontal reference; high during valid samples |
| sample_in | input | DATA_W | Interleaved chroma/luma sample bus |
| sample_out | output | DATA_W | Sample data aligned with the qualifiers |
| sample_valid | output | 1 | Luma sample on an odd active line of an armed frame |
| luma_phase | output | 1 | 1 when the aligned sample is luminance |
| line_lsb | output | 1 | Bit 0 of the line count |
| line_count | output | LINE_W | Lines since the last frame start |
| frame_start | output | 1 | One-cycle pulse on a field-flag rise |
| store_field | output | 1 | Current frame is a store frame |
| compare_field | output | 1 | Current frame is a compare frame |

## Verification
The bench drives active lines with vref and href toggling before any field-flag rise. A design that let these through would raise sample_valid or a frame role with no frame framed. It lines up a field-flag rise with an href rise in the same cycle: a design that used the old line count or restarted the phase late would qualify a sample on the wrong line parity. It also applies one-sample href runs, which must never yield luma, and a short low glitch on the field flag, which must start a new frame and flip the store/compare role. Randomly sized lines and fields with random data then check each output, on every cycle, against a reference model built from the requirements.

// File: rtl/pal_seq_pkg.sv
// Shared definitions for the field capture sequencer.
// Assumes the three sync inputs are gathered into one vector at the indices below.
package pal_seq_pkg;
    localparam int SYNC_N    = 3;
    localparam int IDX_FIELD = 0;
    localparam int IDX_VREF  = 1;
    localparam int IDX_HREF  = 2;

    // Per-signal view: registered level plus edge flags for the same cycle.
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } sync_ev_t;
endpackage

// File: rtl/pal_sync_edges.sv
// Registers each sync input once, keeps its previous value, and reports
// the level together with rise and fall flags.
// Assumes the inputs are already synchronous to clk (decoder pixel clock).
module pal_sync_edges
    import pal_seq_pkg::*;
#(
    parameter int N = SYNC_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         raw,
    output sync_ev_t [N-1:0]     ev
);
    for (genvar i = 0; i < N; i++) begin : g_sync
        logic stage_q;
        logic prev_q;

        // Capture the raw level and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= 1'b0;
                prev_q  <= 1'b0;
            end else begin
                stage_q <= raw[i];
                prev_q  <= stage_q;
            end
        end

        // Level, rising edge and falling edge for this cycle.
        assign ev[i] = {stage_q, stage_q & ~prev_q, ~stage_q & prev_q};
    end
endmodule

// File: rtl/pal_line_tracker.sv
// Counts lines from the last field-flag rise, remembers whether any frame
// has started since reset, and alternates the store/compare role.
// Outputs are the values for the current sample: a frame start in this
// cycle already takes effect, while an href fall only counts from the next one.
module pal_line_tracker #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_rise,
    input  logic              href_fall,
    output logic [LINE_W-1:0] cnt_eff,
    output logic              armed_eff,
    output logic              store_eff
);
    logic [LINE_W-1:0] cnt_q;
    logic              armed_q;
    logic              role_q;

    // Values seen by the current sample.
    always_comb begin
        cnt_eff   = field_rise ? '0 : cnt_q;
        armed_eff = armed_q | field_rise;
        store_eff = field_rise ? ~role_q : role_q;
    end

    // Advance the count on an href fall and keep the frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            role_q  <= 1'b0;
        end else begin
            cnt_q   <= href_fall ? cnt_eff + 1'b1 : cnt_eff;
            armed_q <= armed_eff;
            role_q  <= store_eff;
        end
    end

    // R6
    armed_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_rise |=> armed_q);

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_rise && !href_fall && !$past(field_rise) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/pal_phase_tracker.sv
// Follows the chroma/luma alternation of the interleaved sample stream.
// The first sample of every href-high run is taken as chroma and the phase
// toggles on each sample after it. luma is forced low while href is low.
module pal_phase_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic href_lvl,
    input  logic href_rise,
    output logic luma
);
    logic ph_q;
    logic ph_eff;

    // Phase for the current sample: restart at an href rise, else toggle.
    always_comb begin
        ph_eff = href_rise ? 1'b0 : ~ph_q;
        luma   = href_lvl & ph_eff;
    end

    // Keep the phase for the next sample.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_eff;
    end

    // R4
    run_start_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        href_rise |-> !luma);
endmodule

// File: rtl/pal_field_sequencer.sv
// Capture sequencer for 4:2:2 PAL decoder output. Frames start on a rising
// field flag. Luma samples on odd lines within vref are marked valid, and
// frames take turns as store and compare frames.
// Assumes all inputs are synchronous to the pixel clock. Outputs lag the
// inputs by two clock edges and sample_out is aligned with them.
module pal_field_sequencer
    import pal_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_odd,
    input  logic              vref,
    input  logic              href,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] sample_out,
    output logic              sample_valid,
    output logic              luma_phase,
    output logic              line_lsb,
    output logic [LINE_W-1:0] line_count,
    output logic              frame_start,
    output logic              store_field,
    output logic              compare_field
);
    logic [SYNC_N-1:0]    raw;
    sync_ev_t [SYNC_N-1:0] ev;
    logic [DATA_W-1:0]    data_a;
    logic [LINE_W-1:0]    cnt_eff;
    logic                 armed_eff;
    logic                 store_eff;
    logic                 luma;
    logic                 valid_c;

    // Gather the sync inputs at their package indices.
    always_comb begin
        raw            = '0;
        raw[IDX_FIELD] = field_odd;
        raw[IDX_VREF]  = vref;
        raw[IDX_HREF]  = href;
    end

    pal_sync_edges #(.N(SYNC_N)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .ev    (ev)
    );

    pal_line_tracker #(.LINE_W(LINE_W)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_rise (ev[IDX_FIELD].rise),
        .href_fall  (ev[IDX_HREF].fall),
        .cnt_eff    (cnt_eff),
        .armed_eff  (armed_eff),
        .store_eff  (store_eff)
    );

    pal_phase_tracker u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .href_lvl  (ev[IDX_HREF].lvl),
        .href_rise (ev[IDX_HREF].rise),
        .luma      (luma)
    );

    // Capture the sample bus in step with the sync levels.
    always_ff @(posedge clk) begin
        if (!rst_n) data_a <= '0;
        else        data_a <= sample_in;
    end

    // Qualify luma samples on odd lines inside vref of an armed frame.
    always_comb begin
        valid_c = armed_eff & ev[IDX_VREF].lvl & luma & cnt_eff[0];
    end

    // Register every output so that all of them line up with sample_out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out    <= '0;
            sample_valid  <= 1'b0;
            luma_phase    <= 1'b0;
            line_lsb      <= 1'b0;
            line_count    <= '0;
            frame_start   <= 1'b0;
            store_field   <= 1'b0;
            compare_field <= 1'b0;
        end else begin
            sample_out    <= data_a;
            sample_valid  <= valid_c;
            luma_phase    <= luma;
            line_lsb      <= cnt_eff[0];
            line_count    <= cnt_eff;
            frame_start   <= ev[IDX_FIELD].rise;
            store_field   <= armed_eff & store_eff;
            compare_field <= armed_eff & ~store_eff;
        end
    end

    // R2
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R3
    fs_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_count == '0);

    // R4
    luma_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        luma_phase |=> !luma_phase);

    // R5
    valid_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> luma_phase && line_lsb);

    // R6
    valid_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> store_field || compare_field);

    // R7
    role_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_field && compare_field));

    // R7
    role_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && $past(store_field) |-> compare_field);
endmodule

// File: tb/sim_pal_field_sequencer.sv
`timescale 1ns/1ps
module sim_pal_field_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       field_odd = 1'b0;
    logic       vref = 1'b0;
    logic       href = 1'b0;
    logic [7:0] sample_in = 8'h00;
    logic [7:0] sample_out;
    logic       sample_valid, luma_phase, line_lsb, frame_start, store_field, compare_field;
    logic [9:0] line_count;

    always #2.5 clk = ~clk;

    pal_field_sequencer #(.DATA_W(8), .LINE_W(10)) u0 (
        .clk(clk), .rst_n(rst_n), .field_odd(field_odd), .vref(vref), .href(href),
        .sample_in(sample_in), .sample_out(sample_out), .sample_valid(sample_valid),
        .luma_phase(luma_phase), .line_lsb(line_lsb), .line_count(line_count),
        .frame_start(frame_start), .store_field(store_field), .compare_field(compare_field)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       fs, sv, lp, ll, st, cp, ar;
        logic [9:0] lc;
    } exp_t;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t e1, e2;
    bit   en1 = 0, en2 = 0;
    // Reference model state, built from the requirements.
    logic m_pf, m_ph_prev_h, m_armed, m_role, m_ph;
    logic [9:0] m_cnt;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(input exp_t e);
        chk("R8 sample_out", sample_out, e.d);
        chk("R2 frame_start", frame_start, e.fs);
        chk("R3 line_count", line_count, e.lc);
        chk("R3 line_lsb", line_lsb, e.ll);
        chk("R4 luma_phase", luma_phase, e.lp);
        chk(e.ar ? "R5 sample_valid" : "R6 sample_valid", sample_valid, e.sv);
        chk("R7 store_field", store_field, e.st);
        chk("R7 compare_field", compare_field, e.cp);
    endtask

    task automatic model_reset();
        m_pf = 0; m_ph_prev_h = 0; m_armed = 0; m_role = 0; m_ph = 0; m_cnt = '0;
    endtask

    // Check the outputs due now, then drive new inputs and predict their outputs.
    task automatic step_body(input logic f, input logic v, input logic h, input logic [7:0] d);
        logic rise, hfall, hrise, ph_e, arm_e, role_e;
        logic [9:0] cnt_e;
        if (en2) check_out(e2);
        e2 = e1; en2 = en1;
        field_odd = f; vref = v; href = h; sample_in = d;
        rise  = f & ~m_pf;
        hfall = ~h & m_ph_prev_h;
        hrise = h & ~m_ph_prev_h;
        cnt_e  = rise ? 10'd0 : m_cnt;
        arm_e  = m_armed | rise;
        role_e = rise ? ~m_role : m_role;
        ph_e   = hrise ? 1'b0 : ~m_ph;
        e1.d  = d;
        e1.fs = rise;
        e1.lc = cnt_e;
        e1.ll = cnt_e[0];
        e1.lp = h & ph_e;
        e1.ar = arm_e;
        e1.sv = arm_e & v & h & ph_e & cnt_e[0];
        e1.st = arm_e & role_e;
        e1.cp = arm_e & ~role_e;
        en1 = 1;
        m_cnt = hfall ? cnt_e + 10'd1 : cnt_e;
        m_armed = arm_e; m_role = role_e; m_ph = ph_e;
        m_pf = f; m_ph_prev_h = h;
    endtask

    task automatic tick(input logic f, input logic v, input logic h);
        @(negedge clk);
        step_body(f, v, h, 8'($urandom));
    endtask

    task automatic line_seq(input logic f, input logic v, input int hblank, input int hlen);
        repeat (hblank) tick(f, v, 1'b0);
        repeat (hlen) tick(f, v, 1'b1);
    endtask

    task automatic field_rand(input logic f);
        int nb, na;
        nb = $urandom_range(1, 3);
        na = $urandom_range(3, 8);
        repeat (nb) line_seq(f, 1'b0, $urandom_range(2, 6), $urandom_range(4, 16));
        repeat (na) line_seq(f, 1'b1, $urandom_range(2, 6), $urandom_range(1, 16));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // R1: outputs held at zero during reset
        repeat (4) begin
            @(negedge clk);
            chk("R1 sample_out", sample_out, 0);
            chk("R1 quals", {sample_valid, luma_phase, line_lsb, frame_start, store_field, compare_field}, 0);
            chk("R1 line_count", line_count, 0);
        end
        rst_n = 1'b1;
        step_body(1'b0, 1'b0, 1'b0, 8'h00);
        // R6: active lines before any frame start must not qualify
        repeat (3) line_seq(1'b0, 1'b1, 3, 8);
        // R2/R3: field rise in the same cycle as an href rise
        repeat (3) tick(1'b0, 1'b1, 1'b0);
        repeat (9) tick(1'b1, 1'b1, 1'b1);
        repeat (4) line_seq(1'b1, 1'b1, 3, 7);
        // R4: single-sample href runs never give luma
        repeat (4) line_seq(1'b1, 1'b1, 2, 1);
        // R7: short field-flag glitch starts a new frame and flips the role
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        repeat (3) line_seq(1'b1, 1'b1, 2, 6);
        // Random frames: odd field then even field
        repeat (10) begin
            field_rand(1'b1);
            field_rand(1'b0);
        end
        repeat (4) tick(1'b0, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule